// File: doc/BRIEF.md
# Nixie Time Frame Serializer

This block turns a time of day into the serial bit stream for a chain of six 8-bit serial-in, parallel-out shift registers. Each register feeds one nixie digit decoder and the separator lamp drivers. On a one-cycle start strobe it captures hours, minutes and seconds. It clamps out-of-range values and adds a fixed three-hour zone offset to the hour. It then splits each field into tens and units, and converts each decimal digit to the scrambled 4-bit code that the decoders expect.

The frame is 48 bits, shifted out most significant bit first on a data line with a separate shift clock. After the last bit, one latch pulse moves the whole frame to the register outputs. Each 8-bit slot holds one digit code and four copies of a separator flag. The flag inverts after every frame, so the separator lamps blink when a frame is sent once per second. A programmable divider sets the length of each clock phase, so the external chain sees a slow, clean waveform.

Top module: `nixie_frame_tx`

## Requirements
- R1: While and after reset, ser_data, ser_clk, ser_latch, busy and done are 0 and sep_blink is 0.
- R2: Digit d is sent as code CODE[d], where CODE = {0:11, 1:9, 2:12, 3:8, 4:0, 5:4, 6:1, 7:3, 8:2, 9:10}.
- R3: The frame is six 8-bit slots sent in this order: hour tens, hour units, minute tens, minute units, second tens, second units. A slot is sent as flag, code bit 3, code bit 2, code bit 1, code bit 0, flag, flag, flag, where flag is the sep_blink value when the frame started.
- R4: With P = half_period (0 is treated as 1), each bit is placed on ser_data while ser_clk is low for P cycles, then ser_clk is high for P cycles. ser_data does not change while ser_clk is high, and a receiver takes each bit on the rising edge of ser_clk.
- R5: Exactly 48 ser_clk pulses precede one ser_latch pulse of P cycles. ser_latch rises on the same edge as the 48th falling edge of ser_clk and is never high together with ser_clk.
- R6: sep_blink inverts once at the end of every frame.
- R7: The hour sent is (clamped hour + 3) mod 24.
- R8: Hours above 23 are sent as 23 before the offset. Minutes and seconds above 59 are sent as 59.
- R9: A start strobe while idle captures the inputs and raises busy on the next edge. Start strobes while busy are ignored and change neither the frame being sent nor the number of latch pulses.
- R10: done is high for exactly one cycle, on the edge where ser_latch falls, and busy falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a frame |
| hours | input | 5 | Hour of day, 0..23 (larger values are clamped) |
| minutes | input | 6 | Minute, 0..59 (larger values are clamped) |
| seconds | input | 6 | Second, 0..59 (larger values are clamped) |
| half_period | input | 8 | Cycles per shift-clock phase (0 acts as 1) |
| ser_data | output | 1 | Serial data to the register chain |
| ser_clk | output | 1 | Shift clock to the register chain |
| ser_latch | output | 1 | Storage latch strobe to the register chain |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sep_blink | output | 1 | Separator flag used for the next frame |

## Verification
The start strobe is applied at a falling clock edge and captured on the next rising edge. busy is due one edge later, and the first data bit with the clock low is due on that same edge. From there every clock phase, the latch pulse and done follow P-cycle steps. The bench samples every falling edge and measures the run lengths of ser_clk and ser_latch rather than assuming absolute cycle numbers. It collects data bits at each rising ser_clk, compares the 48 captured bits with a frame built arithmetically from the inputs, and checks blink and done at the sample where done is first seen and at the one after.

// File: rtl/nixie_pkg.sv
package nixie_pkg;

    localparam int DIGITS    = 6;
    localparam int SLOT_W    = 8;
    localparam int CODE_W    = 4;
    localparam int FRAME_W   = DIGITS * SLOT_W;
    localparam int BIT_IDX_W = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LATCH
    } seq_state_e;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } tod_t;

    // Scrambled decimal-to-decoder code substitution.
    function automatic logic [CODE_W-1:0] digit_code(input logic [3:0] d);
        logic [CODE_W-1:0] c;
        case (d)
            4'd0:    c = 4'd11;
            4'd1:    c = 4'd9;
            4'd2:    c = 4'd12;
            4'd3:    c = 4'd8;
            4'd4:    c = 4'd0;
            4'd5:    c = 4'd4;
            4'd6:    c = 4'd1;
            4'd7:    c = 4'd3;
            4'd8:    c = 4'd2;
            4'd9:    c = 4'd10;
            default: c = 4'd0;
        endcase
        return c;
    endfunction

    function automatic logic [5:0] clamp_to(input logic [5:0] v, input logic [5:0] top);
        return (v > top) ? top : v;
    endfunction

    function automatic logic [3:0] tens_of(input logic [5:0] v);
        return 4'(v / 6'd10);
    endfunction

    function automatic logic [3:0] units_of(input logic [5:0] v);
        return 4'(v % 6'd10);
    endfunction

    // One slot: flag, code MSB..LSB, then three flag copies.
    function automatic logic [SLOT_W-1:0] make_slot(input logic [CODE_W-1:0] code,
                                                    input logic flag);
        return {flag, code, flag, flag, flag};
    endfunction

endpackage

// File: rtl/nixie_frame_pack.sv
module nixie_frame_pack
    import nixie_pkg::*;
#(
    parameter int HOUR_OFFSET = 3
) (
    input  tod_t               tod,
    input  logic               flag,
    output logic [FRAME_W-1:0] frame
);

    logic [5:0] hr_clamped;
    logic [5:0] mn_clamped;
    logic [5:0] sc_clamped;
    logic [5:0] hr_sum;
    logic [5:0] hr_shown;
    logic [3:0] dig [DIGITS];

    always_comb begin
        hr_clamped = clamp_to({1'b0, tod.hr}, 6'd23);
        mn_clamped = clamp_to(tod.mn, 6'd59);
        sc_clamped = clamp_to(tod.sc, 6'd59);
        hr_sum     = hr_clamped + 6'(HOUR_OFFSET);
        hr_shown   = (hr_sum >= 6'd24) ? (hr_sum - 6'd24) : hr_sum;
        dig[0]     = tens_of(hr_shown);
        dig[1]     = units_of(hr_shown);
        dig[2]     = tens_of(mn_clamped);
        dig[3]     = units_of(mn_clamped);
        dig[4]     = tens_of(sc_clamped);
        dig[5]     = units_of(sc_clamped);
    end

    // Slot 0 occupies the top bits so it leaves the shifter first.
    for (genvar g = 0; g < DIGITS; g++) begin : g_slot
        assign frame[FRAME_W-1-g*SLOT_W -: SLOT_W] = make_slot(digit_code(dig[g]), flag);
    end

endmodule

// File: rtl/nixie_phase_timer.sv
module nixie_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (half == '0) ? DIV_W'(1) : half;
    assign tick  = !clear && (cnt == limit - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/nixie_shift_seq.sv
module nixie_shift_seq
    import nixie_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               tick,
    output logic               timer_clear,
    output logic               sdata,
    output logic               sclk,
    output logic               slatch,
    output logic               busy,
    output logic               done,
    output logic               blink
);

    seq_state_e           state;
    logic [FRAME_W-1:0]   shreg;
    logic [BIT_IDX_W-1:0] idx;

    assign timer_clear = (state == ST_IDLE);
    assign busy        = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            idx    <= '0;
            sdata  <= 1'b0;
            sclk   <= 1'b0;
            slatch <= 1'b0;
            done   <= 1'b0;
            blink  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sdata <= frame_in[FRAME_W-1];
                        shreg <= frame_in << 1;
                        idx   <= '0;
                        state <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (idx == BIT_IDX_W'(FRAME_W - 1)) begin
                            sdata  <= 1'b0;
                            slatch <= 1'b1;
                            state  <= ST_LATCH;
                        end else begin
                            sdata <= shreg[FRAME_W-1];
                            shreg <= shreg << 1;
                            idx   <= idx + BIT_IDX_W'(1);
                            state <= ST_LOW;
                        end
                    end
                end
                ST_LATCH: begin
                    if (tick) begin
                        slatch <= 1'b0;
                        done   <= 1'b1;
                        blink  <= ~blink;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nixie_frame_tx.sv
module nixie_frame_tx
    import nixie_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int HOUR_OFFSET = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [4:0]       hours,
    input  logic [5:0]       minutes,
    input  logic [5:0]       seconds,
    input  logic [DIV_W-1:0] half_period,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             ser_latch,
    output logic             busy,
    output logic             done,
    output logic             sep_blink
);

    tod_t               tod;
    logic [FRAME_W-1:0] frame;
    logic               tick;
    logic               timer_clear;

    assign tod = '{hr: hours, mn: minutes, sc: seconds};

    nixie_frame_pack #(.HOUR_OFFSET(HOUR_OFFSET)) u_pack (
        .tod   (tod),
        .flag  (sep_blink),
        .frame (frame)
    );

    nixie_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (timer_clear),
        .half  (half_period),
        .tick  (tick)
    );

    nixie_shift_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .frame_in    (frame),
        .tick        (tick),
        .timer_clear (timer_clear),
        .sdata       (ser_data),
        .sclk        (ser_clk),
        .slatch      (ser_latch),
        .busy        (busy),
        .done        (done),
        .blink       (sep_blink)
    );

endmodule

// File: rtl/nixie_frame_tx_chk.sv
module nixie_frame_tx_chk #(
    parameter int FRAME_W = 48
) (
    input logic clk,
    input logic rst,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_latch,
    input logic busy,
    input logic done,
    input logic sep_blink
);

    logic        clk_q;
    logic        latch_q;
    int unsigned rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q    <= 1'b0;
            latch_q  <= 1'b0;
            rise_cnt <= 0;
        end else begin
            clk_q   <= ser_clk;
            latch_q <= ser_latch;
            if (ser_latch && !latch_q) begin
                rise_cnt <= 0;
            end else if (ser_clk && !clk_q) begin
                rise_cnt <= rise_cnt + 1;
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ser_data && !ser_clk && !ser_latch && !busy && !done && !sep_blink));

    a_r4_data_held_high: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data));

    a_r5_latch_after_full_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_latch) |-> (rise_cnt == FRAME_W));

    a_r5_latch_clk_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ser_clk && ser_latch));

    a_r6_blink_flips: assert property (@(posedge clk) disable iff (rst)
        done |-> (sep_blink != $past(sep_blink)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_on_latch_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> ($fell(ser_latch) && !busy));

    a_r9_idle_lines_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_clk && !ser_latch));

endmodule

bind nixie_frame_tx nixie_frame_tx_chk #(.FRAME_W(nixie_pkg::FRAME_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .ser_latch (ser_latch),
    .busy      (busy),
    .done      (done),
    .sep_blink (sep_blink)
);

// File: tb/sim_nixie_frame_tx.sv
module sim_nixie_frame_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [4:0] hours = '0;
    logic [5:0] minutes = '0;
    logic [5:0] seconds = '0;
    logic [7:0] half_period = 8'd1;
    logic       ser_data, ser_clk, ser_latch, busy, done, sep_blink;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cycles   = 0;
    bit  exp_blink = 1'b0;

    always #4 clk = ~clk;

    nixie_frame_tx u0 (
        .clk(clk), .rst(rst), .start(start), .hours(hours), .minutes(minutes),
        .seconds(seconds), .half_period(half_period), .ser_data(ser_data),
        .ser_clk(ser_clk), .ser_latch(ser_latch), .busy(busy), .done(done),
        .sep_blink(sep_blink)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] build_frame(input int h, input int m, input int s, input bit b);
        int lut [10] = '{11, 9, 12, 8, 0, 4, 1, 3, 2, 10};
        int hc, mc, sc, hh;
        int d [6];
        logic [47:0] f;
        logic [3:0]  c;
        hc = (h > 23) ? 23 : h;
        mc = (m > 59) ? 59 : m;
        sc = (s > 59) ? 59 : s;
        hh = (hc + 3) % 24;
        d  = '{hh / 10, hh % 10, mc / 10, mc % 10, sc / 10, sc % 10};
        f  = '0;
        for (int i = 0; i < 6; i++) begin
            c = 4'(lut[d[i]]);
            f = {f[39:0], b, c, b, b, b};
        end
        return f;
    endfunction

    task automatic run_frame(input int h, input int m, input int s, input int d,
                             input bit poke, input string tag);
        logic [47:0] exp_f, got;
        int  dd, nbits, hi_run, lo_run, lat_run, latch_pulses, early, bad_hi, bad_lo, both, guard;
        bit  prev_clk, prev_lat, seen_done, poked;
        dd = (d == 0) ? 1 : d;
        exp_f = build_frame(h, m, s, exp_blink);
        got = '0; nbits = 0; hi_run = 0; lo_run = 0; lat_run = 0; latch_pulses = 0;
        early = 0; bad_hi = 0; bad_lo = 0; both = 0; guard = 0;
        prev_clk = 0; prev_lat = 0; seen_done = 0; poked = 0;
        @(negedge clk);
        hours = 5'(h); minutes = 6'(m); seconds = 6'(s); half_period = 8'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
        while (!seen_done && guard < 5000) begin
            guard++;
            if (ser_clk && ser_latch) both++;
            if (ser_clk) begin
                if (!prev_clk) begin
                    got = {got[46:0], ser_data};
                    nbits++;
                    if (lo_run != dd) bad_lo++;
                    hi_run = 0;
                end
                hi_run++;
            end else begin
                if (prev_clk) begin
                    if (hi_run != dd) bad_hi++;
                    lo_run = 0;
                end
                lo_run++;
            end
            if (ser_latch) begin
                if (!prev_lat) begin
                    latch_pulses++;
                    if (nbits != 48) early++;
                    lat_run = 0;
                end
                lat_run++;
            end
            if (done) begin
                seen_done = 1;
                chk(!busy && !ser_latch, "R10", "busy/latch low with done",
                    64'({busy, ser_latch}), 64'd0);
                chk(sep_blink == !exp_blink, "R6", "blink inverted at frame end",
                    64'(sep_blink), 64'(!exp_blink));
            end
            prev_clk = ser_clk;
            prev_lat = ser_latch;
            if (start) start = 1'b0;
            if (poke && !poked && nbits == 10) begin
                poked = 1;
                hours = 5'd7; minutes = 6'd11; seconds = 6'd22;
                start = 1'b1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen_done, "R10", "done seen", 64'(seen_done), 64'd1);
        chk(done === 1'b0, "R10", "done lasts one cycle", 64'(done), 64'd0);
        chk(got == exp_f, tag, "frame bits", 64'(got), 64'(exp_f));
        chk(nbits == 48, "R5", "clock pulses", 64'(nbits), 64'd48);
        chk(latch_pulses == 1 && early == 0, "R5", "single latch after 48 bits",
            64'(latch_pulses), 64'd1);
        chk(lat_run == dd, "R5", "latch width", 64'(lat_run), 64'(dd));
        chk(bad_hi == 0 && bad_lo == 0, "R4", "clock phase widths",
            64'(bad_hi + bad_lo), 64'd0);
        chk(both == 0, "R5", "latch and clock overlap", 64'(both), 64'd0);
        exp_blink = !exp_blink;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({ser_data, ser_clk, ser_latch, busy, done, sep_blink} == 6'b0, "R1",
            "outputs during reset", 64'({ser_data, ser_clk, ser_latch, busy, done, sep_blink}), 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({ser_data, ser_clk, ser_latch, busy, done, sep_blink} == 6'b0, "R1",
            "outputs after reset", 64'({ser_data, ser_clk, ser_latch, busy, done, sep_blink}), 64'd0);

        // R2 R3 basic frame
        run_frame(12, 34, 56, 1, 0, "R2/R3");
        run_frame(17, 8, 9, 1, 0, "R2/R3");
        // R7 R8 every hour value including clamped ones
        for (int h = 0; h < 32; h++) begin
            run_frame(h, (h * 7) % 64, (h * 13 + 5) % 64, 1, 0, "R7/R8");
        end
        // R8 minute and second sweep over the whole 6-bit range
        for (int i = 0; i < 64; i++) begin
            run_frame(i % 24, i, 63 - i, 1, 0, "R8");
        end
        // R4 divider settings, zero acting as one
        run_frame(9, 45, 30, 0, 0, "R4");
        run_frame(20, 59, 0, 3, 0, "R4");
        run_frame(5, 1, 49, 5, 0, "R4");
        // R9 start while busy is ignored
        run_frame(21, 43, 10, 2, 1, "R9");
        run_frame(0, 0, 0, 1, 0, "R6");
        repeat (5) @(negedge clk);
        chk(!busy && !ser_clk && !ser_latch, "R9", "idle after frames",
            64'({busy, ser_clk, ser_latch}), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule